// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block provides two independent countdown channels behind one word-wide register bus. Each channel divides the system clock by a programmable amount from 1 to 256, then uses the divided tick to step a 32-bit counter down from a programmed start value. When the count runs out, the channel raises an expiry flag. A channel set to one-shot then stops. A channel set to periodic reloads its start value and keeps running. Each channel drives a level interrupt, which is the expiry flag gated by that channel's interrupt enable.

Software programs a start value, then writes the control word to select the divide ratio, the mode, the interrupt enable and the run bit. The live count can be read at any time with no side effects. A periodic channel loaded with all ones acts as a free-running time base. Both channels record their expiry flags in one shared status word, and writing a one to a flag bit clears that flag.

Top module: `tmr_dual`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, both channels are stopped and both interrupt outputs are low.
- R2: While a channel runs, its count drops by exactly one on every (P+1)-th clock, where P is control bits 7:0. The first decrement comes P+1 clocks after the write that sets the run bit.
- R3: Control bits 28:27 select the mode, and value 01 is periodic. When a periodic channel expires, it reloads its start value and keeps running, so a start value of 0xFFFFFFFF gives a free-running down counter.
- R4: Any mode value other than 01 is one-shot. On expiry a one-shot channel leaves its count at 0, clears its own run bit (control bit 30) and stays stopped.
- R5: Expiry happens on a divided tick that finds the count at 1 or 0. The channel's interrupt output is high exactly while its expiry flag is set and its interrupt enable (control bit 29) is set.
- R6: The status word holds channel 0's expiry flag in bit 0 and channel 1's in bit 1. Writing a 1 to a bit clears that flag, and writing 0x1F clears both. A flag set in the same cycle as a clear stays set.
- R7: A write to a channel's start-value register loads the count at once and restarts the prescaler phase. This holds even while the channel is running.
- R8: The count register is read-only. Writes to it are ignored, and reads have no side effect.
- R9: Channel c uses word addresses 4c (control), 4c+1 (start value) and 4c+2 (count). The status word is at address 8. Every other address reads zero and ignores writes. Unused control bits read zero.
- R10: A channel whose run bit is clear holds its count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 2 | Level interrupt, one bit per channel |

## Verification
The hardest cases to reach are collisions between an expiry and a bus write in the same clock. Examples are a status clear landing on the cycle a flag is set, a start-value write landing on the expiring tick, and a control write landing on the cycle a one-shot channel clears its own run bit. The random stimulus makes these collisions frequent. It keeps divide ratios at 1 to 4 and start values at 0 to 12, and it issues a bus operation in most cycles. A cycle-by-cycle reference model in the bench predicts every read and the interrupt outputs. Directed sequences cover the exact timing of the first tick, one-shot stop, periodic reload and free-running wrap.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared field positions, mode encoding and control word layout for the timer.
// Assumes a 32-bit bus word; the control field positions are fixed by software.
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int PSC_W     = 8;
    localparam int MODE_LSB  = 27;
    localparam int IE_BIT    = 29;
    localparam int EN_BIT    = 30;
    localparam int SLOT_W    = 4;   // words per channel window
    localparam int OFF_CTRL  = 0;
    localparam int OFF_START = 1;
    localparam int OFF_COUNT = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_REPEAT   = 2'b01,
        MODE_RSVD_A   = 2'b10,
        MODE_RSVD_B   = 2'b11
    } mode_e;

    typedef struct packed {
        logic             run;
        logic             ie;
        mode_e            mode;
        logic [PSC_W-1:0] div;
    } ctrl_t;

    // Unpack a bus word into control fields.
    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run  = w[EN_BIT];
        c.ie   = w[IE_BIT];
        c.mode = mode_e'(w[MODE_LSB+1:MODE_LSB]);
        c.div  = w[PSC_W-1:0];
        return c;
    endfunction

    // Pack control fields into a bus word, unused bits zero.
    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT]                   = c.run;
        w[IE_BIT]                   = c.ie;
        w[MODE_LSB+1:MODE_LSB]      = c.mode;
        w[PSC_W-1:0]                = c.div;
        return w;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Clock divider: emits a one-cycle tick every (div+1) clocks while run is high.
// Assumes restart has priority; phase holds while stopped. A div lowered below
// the current phase fires on the next cycle instead of wrapping.
module tmr_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] phase_q;

    // Tick when the phase has reached the divide value.
    assign tick = run && (phase_q >= div);

    // Advance or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_status.sv
`timescale 1ns/1ps
// Shared expiry flag word: set by channel expiry, cleared by write-one.
// Assumes a set and a clear in the same cycle leave the flag set.
module tmr_status #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] set,
    output logic [NCH-1:0] flags
);
    logic [NCH-1:0] clr_eff;

    // Clear mask only counts during a status write.
    assign clr_eff = clr_we ? clr_mask : '0;

    // Update flags with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_eff) | set;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One countdown channel: control register, start value, live count and its
// prescaler. Assumes at most one of ctrl_we/start_we per cycle (one bus write).
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  ctrl_t         ctrl_in,
    input  logic          start_we,
    input  logic [CW-1:0] start_in,
    output ctrl_t         ctrl,
    output logic [CW-1:0] start_val,
    output logic [CW-1:0] count,
    output logic          repeat_mode,
    output logic          expire
);
    logic tick;
    logic restart;

    // Restart phase on a new start value or on a stopped-to-running write.
    assign restart     = start_we || (ctrl_we && ctrl_in.run && !ctrl.run);
    assign repeat_mode = (ctrl.mode == MODE_REPEAT);
    assign expire      = tick && (count <= CW'(1));

    tmr_prescaler #(.PW(PSC_W)) psc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .restart (restart),
        .div     (ctrl.div),
        .tick    (tick)
    );

    // Control register; a one-shot expiry drops the run bit unless rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl <= ctrl_in;
        end else if (expire && !repeat_mode) begin
            ctrl.run <= 1'b0;
        end
    end

    // Start value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
        end else if (start_we) begin
            start_val <= start_in;
        end
    end

    // Live count: start write wins, then expiry handling, then plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start_we) begin
            count <= start_in;
        end else if (expire) begin
            count <= repeat_mode ? start_val : '0;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_dual.sv
`timescale 1ns/1ps
// Multi-channel interval timer with a word-addressed register bus.
// Channel c owns words 4c..4c+3; the shared status word follows the last
// channel. Reads are combinational and free of side effects.
module tmr_dual
    import tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NCH-1:0]      irq
);
    localparam int STATUS_WORD = NCH * SLOT_W;

    ctrl_t                     ch_ctrl  [NCH];
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;
    logic [NCH-1:0][CNT_W-1:0] ch_start;
    logic [NCH-1:0]            ch_en;
    logic [NCH-1:0]            ch_ie;
    logic [NCH-1:0]            ch_rep;
    logic [NCH-1:0]            ch_exp;
    logic [NCH-1:0]            flags;
    logic                      status_we;
    ctrl_t                     ctrl_in;

    // Decode the shared fields of a write once.
    assign ctrl_in   = word_to_ctrl(bus_wdata);
    assign status_we = bus_wr && (bus_addr == ADDR_W'(STATUS_WORD));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(c * SLOT_W + OFF_CTRL);
        localparam logic [ADDR_W-1:0] A_START = ADDR_W'(c * SLOT_W + OFF_START);
        logic ctrl_we;
        logic start_we;

        // Per-channel write strobes.
        assign ctrl_we  = bus_wr && (bus_addr == A_CTRL);
        assign start_we = bus_wr && (bus_addr == A_START);

        tmr_channel #(.CW(CNT_W)) ch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_we     (ctrl_we),
            .ctrl_in     (ctrl_in),
            .start_we    (start_we),
            .start_in    (bus_wdata[CNT_W-1:0]),
            .ctrl        (ch_ctrl[c]),
            .start_val   (ch_start[c]),
            .count       (ch_cnt[c]),
            .repeat_mode (ch_rep[c]),
            .expire      (ch_exp[c])
        );

        // Flatten control bits used by the interrupt gate and the checker.
        assign ch_en[c] = ch_ctrl[c].run;
        assign ch_ie[c] = ch_ctrl[c].ie;
    end

    tmr_status #(.NCH(NCH)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (status_we),
        .clr_mask (bus_wdata[NCH-1:0]),
        .set      (ch_exp),
        .flags    (flags)
    );

    // Level interrupts: flag gated by enable.
    assign irq = flags & ch_ie;

    // Read multiplexer; unmapped words return zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(c * SLOT_W + OFF_CTRL)) begin
                bus_rdata = ctrl_to_word(ch_ctrl[c]);
            end
            if (bus_addr == ADDR_W'(c * SLOT_W + OFF_START)) begin
                bus_rdata[CNT_W-1:0] = ch_start[c];
            end
            if (bus_addr == ADDR_W'(c * SLOT_W + OFF_COUNT)) begin
                bus_rdata[CNT_W-1:0] = ch_cnt[c];
            end
        end
        if (bus_addr == ADDR_W'(STATUS_WORD)) begin
            bus_rdata[NCH-1:0] = flags;
        end
    end
endmodule

// File: rtl/tmr_dual_chk.sv
`timescale 1ns/1ps
// Property checker for tmr_dual, attached by bind. Assumes any bus write may
// touch a channel, so per-cycle properties are only claimed on idle cycles.
module tmr_dual_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [NCH-1:0]             irq,
    input logic [NCH-1:0]             en,
    input logic [NCH-1:0]             ie,
    input logic [NCH-1:0]             rep,
    input logic [NCH-1:0]             expire,
    input logic [NCH-1:0]             flags,
    input logic [NCH-1:0][CNT_W-1:0]  cnt,
    input logic [NCH-1:0][CNT_W-1:0]  start
);
    for (genvar c = 0; c < NCH; c++) begin : g_prop
        AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (en[c] && !bus_wr && !expire[c]) |=>
            (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) - CNT_W'(1))); // R2
        AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[c] && rep[c] && !bus_wr) |=> (cnt[c] == $past(start[c]) && en[c])); // R3
        AST_SINGLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[c] && !rep[c] && !bus_wr) |=> (!en[c] && cnt[c] == '0)); // R4
        AST_IRQ_FOLLOWS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[c] && ie[c] && !bus_wr) |=> irq[c]); // R5
        AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> flags[c]); // R6
        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[c] && !bus_wr) |=> $stable(cnt[c])); // R10
    end
endmodule

bind tmr_dual tmr_dual_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_wr (bus_wr),
    .irq    (irq),
    .en     (ch_en),
    .ie     (ch_ie),
    .rep    (ch_rep),
    .expire (ch_exp),
    .flags  (flags),
    .cnt    (ch_cnt),
    .start  (ch_start)
);

// File: tb/tmr_dual_tb_top.sv
`timescale 1ns/1ps
module tmr_dual_tb_top;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmr_dual dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Reference model state, built from the requirements.
    logic [7:0]  m_div   [NCH];
    logic [1:0]  m_mode  [NCH];
    logic        m_ie    [NCH];
    logic        m_run   [NCH];
    logic [7:0]  m_phase [NCH];
    logic [31:0] m_cnt   [NCH];
    logic [31:0] m_start [NCH];
    logic [1:0]  m_flag;

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_div[c] = 0; m_mode[c] = 0; m_ie[c] = 0; m_run[c] = 0;
            m_phase[c] = 0; m_cnt[c] = 0; m_start[c] = 0;
        end
        m_flag = 0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [31:0] v;
        v = 0;
        for (int c = 0; c < NCH; c++) begin
            if (a == 4'(c * 4))     v = {1'b0, m_run[c], m_ie[c], m_mode[c], 19'd0, m_div[c]};
            if (a == 4'(c * 4 + 1)) v = m_start[c];
            if (a == 4'(c * 4 + 2)) v = m_cnt[c];
        end
        if (a == 4'd8) v = {30'd0, m_flag};
        return v;
    endfunction

    function automatic logic [1:0] exp_irq();
        return m_flag & {m_ie[1], m_ie[0]};
    endfunction

    // Advance the model by one clock edge with the given bus write.
    task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d);
        logic [1:0] setb;
        setb = 0;
        for (int c = 0; c < NCH; c++) begin
            logic tk, ex, per;
            logic [7:0]  nph;
            logic [31:0] ncnt;
            logic        nrun;
            tk   = m_run[c] && (m_phase[c] >= m_div[c]);
            ex   = tk && (m_cnt[c] <= 1);
            per  = (m_mode[c] == 2'b01);
            nph  = m_phase[c];
            ncnt = m_cnt[c];
            nrun = m_run[c];
            if (m_run[c]) nph = tk ? 8'd0 : m_phase[c] + 8'd1;
            if (ex) begin
                ncnt = per ? m_start[c] : 32'd0;
                if (!per) nrun = 0;
                setb[c] = 1'b1;
            end else if (tk) begin
                ncnt = m_cnt[c] - 1;
            end
            if (w && a == 4'(c * 4)) begin
                if (d[30] && !m_run[c]) nph = 0;
                nrun      = d[30];
                m_ie[c]   = d[29];
                m_mode[c] = d[28:27];
                m_div[c]  = d[7:0];
            end
            if (w && a == 4'(c * 4 + 1)) begin
                m_start[c] = d;
                ncnt = d;
                nph = 0;
            end
            m_phase[c] = nph;
            m_cnt[c]   = ncnt;
            m_run[c]   = nrun;
        end
        if (w && a == 4'd8) m_flag = m_flag & ~d[1:0];
        m_flag = m_flag | setb;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One bus cycle, started and ended at a falling edge; irq checked after.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        bus_wr = 0;
        #1;
        check("R5 irq", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0);
    endtask

    task automatic rd_model(input string tag, input logic [3:0] a);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic rd_lit(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R9: all words zero after reset, interrupts low.
        for (int a = 0; a < 16; a++) rd_lit("R1 reset read", 4'(a), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);

        // R2 / R4: one-shot, start 5, divide by 4, interrupt enabled.
        cyc(1, 4'd1, 32'd5);
        cyc(1, 4'd0, 32'h6000_0003);
        idle(4);
        rd_lit("R2 first tick", 4'd2, 32'd4);
        idle(15);
        rd_lit("R2 before expiry", 4'd2, 32'd1);
        check("R5 no irq yet", 32'(irq), 32'd0);
        idle(1);
        rd_lit("R4 count zero", 4'd2, 32'd0);
        rd_lit("R4 run cleared", 4'd0, 32'h2000_0003);
        rd_lit("R6 flag0", 4'd8, 32'd1);
        check("R5 irq up", 32'(irq), 32'd1);
        idle(5);
        rd_lit("R4 stays stopped", 4'd2, 32'd0);

        // R6: clearing the other bit leaves flag 0; 0x1F clears all.
        cyc(1, 4'd8, 32'd2);
        rd_lit("R6 partial clear", 4'd8, 32'd1);
        cyc(1, 4'd8, 32'h1F);
        rd_lit("R6 clear all", 4'd8, 32'd0);
        check("R6 irq down", 32'(irq), 32'd0);

        // R8: writes to count are ignored.
        cyc(1, 4'd2, 32'h1234);
        rd_lit("R8 count write ignored", 4'd2, 32'd0);

        // R7: start write while running reloads at once.
        cyc(1, 4'd1, 32'd100);
        cyc(1, 4'd0, 32'h4800_0000);
        idle(10);
        rd_lit("R7 running", 4'd2, 32'd90);
        cyc(1, 4'd1, 32'd50);
        rd_lit("R7 reload", 4'd2, 32'd50);
        idle(3);
        rd_lit("R7 after reload", 4'd2, 32'd47);

        // R10: stopping holds the count.
        cyc(1, 4'd0, 32'h0800_0000);
        idle(5);
        rd_lit("R10 hold", 4'd2, 32'd46);

        // R3: periodic reload on channel 1, divide by 2.
        cyc(1, 4'd5, 32'd3);
        cyc(1, 4'd4, 32'h6800_0001);
        idle(6);
        rd_lit("R3 reload", 4'd6, 32'd3);
        rd_lit("R3 flag1", 4'd8, 32'd2);
        check("R3 irq1", 32'(irq), 32'd2);
        idle(2);
        rd_lit("R3 keeps running", 4'd6, 32'd2);
        cyc(1, 4'd8, 32'h1F);
        cyc(1, 4'd4, 32'h4800_0000);
        cyc(1, 4'd5, 32'hFFFF_FFFF);
        idle(7);
        rd_lit("R3 free-running", 4'd6, 32'hFFFF_FFF8);
        rd_lit("R9 unmapped", 4'd3, 32'd0);
        cyc(1, 4'd9, 32'hFFFF_FFFF);
        rd_lit("R9 unmapped write", 4'd9, 32'd0);

        // Random phase with model comparison.
        void'($urandom(32'h5EED));
        cyc(1, 4'd4, 32'd0);
        for (int it = 0; it < 6000; it++) begin
            int unsigned op, ch;
            op = $urandom_range(0, 9);
            ch = $urandom_range(0, 1);
            case (op)
                4: cyc(1, 4'(ch * 4), {1'b0, 1'($urandom), 1'($urandom), 2'($urandom),
                                        19'd0, 8'($urandom_range(0, 3))});
                5: cyc(1, 4'(ch * 4 + 1), 32'($urandom_range(0, 12)));
                6: cyc(1, 4'd8, 32'($urandom_range(0, 31)));
                7: cyc(1, 4'(ch * 4 + 2), $urandom);
                8, 9: begin
                    rd_model("R9 random read", 4'($urandom_range(0, 15)));
                    rd_model("R2 random count", 4'(ch * 4 + 2));
                    idle(1);
                end
                default: idle(1);
            endcase
        end
        for (int a = 0; a < 9; a++) rd_model("R8 final read", 4'(a));

        summary();
        $finish;
    end
endmodule